// File: doc/BRIEF.md
# Fractional Pixel Clock Divider

This block derives a display pixel clock from a faster input clock by division with a fractional divisor. The divisor is written as a 12-bit value in sixteenths of an input cycle. It has an 8-bit integer part and a 4-bit fraction. A residue accumulator makes each output period last either the integer count or one cycle more, so that the long-run average period matches the programmed value exactly.

Within each period the block drives a one-cycle strobe on the first input cycle. This strobe is the enable for logic in the pixel domain. It also drives a shaped pixel clock level that is active between a programmable rising position and a programmable falling position, both counted in half input cycles from the start of the period. A control register can invert the shaped clock. It can also select a bypass mode in which the strobe is asserted on every input cycle. New divisor and edge values are applied only at the boundary between periods.

Top module: `fpclk_div`

## Requirements
- R1: After a synchronous active-low reset, the divisor is 0x010 (divide by one) and the edges are rising 0 and falling 1. Inversion and bypass are off, so `pix_stb` and `pix_clk` are both 1 on every cycle.
- R2: A write to register index 0 loads the divisor from `wr_data[11:0]`: bits [3:0] are the fraction and bits [11:4] are the integer part. Each output period lasts either the integer part or one cycle more, in input cycles. Any 16 consecutive periods together last exactly the 12-bit value, counted in input cycles.
- R3: An integer part of 0 is treated as 1. The fraction still applies to it.
- R4: `pix_stb` is 1 on the first input cycle of each output period and 0 on the other cycles. With a divisor of exactly one it is 1 on every cycle.
- R5: A write to register index 1 sets the rising position from `wr_data[8:0]` and the falling position from `wr_data[24:16]`, both in half input cycles. Cycle c of a period (with c = 0 at the strobe) has the active level when rise <= 2c < fall. If fall <= rise, the level is never active.
- R6: A divisor or edge write takes effect only at a period boundary after the write. The period in progress always runs to its old length.
- R7: Bit 0 of register index 2 inverts `pix_clk` from the next cycle on.
- R8: Bit 1 of register index 2 selects bypass. In bypass, `pix_stb` is 1 on every cycle and `pix_clk` is held at the active level (1, or 0 when inverted).
- R9: A write to register index 3 has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register index: 0 divisor, 1 edges, 2 control, 3 unused |
| wr_data | input | 32 | Register write data |
| pix_stb | output | 1 | One-cycle enable at the start of each pixel period |
| pix_clk | output | 1 | Shaped pixel clock level |

## Verification
The bench sweeps every fraction for integer parts 1 to 6. For each setting it checks every period's length and active-cycle count, and checks that 16 consecutive periods sum to the programmed value. A broken accumulator would drift the sum or produce periods two cycles apart. Edge settings with an odd falling position, an inverted window and a window wider than the period are used to expose off-by-one comparisons in the half-cycle domain.

A divisor write is placed in the middle of a long period to catch a design that applies it at once. Such a design would cut the period short and emit a runt. Other checks cover an integer part of 0, which without the clamp would stall the counter, and the bypass and invert controls. A write to the unused register index is also checked for side effects.

// File: rtl/fpd_pkg.sv
// Shared definitions for the fractional pixel clock divider.
// Assumes a two-bit register index on the write port.
package fpd_pkg;
    typedef enum logic [1:0] {
        SEL_DIV  = 2'd0,
        SEL_EDGE = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    localparam int CTRL_INV_BIT = 0;
    localparam int CTRL_BYP_BIT = 1;
endpackage

// File: rtl/fpd_regs.sv
// Register file of the divider: pending divisor and edges, control bits,
// and a flag that marks pending values not yet applied.
// Assumes load_done pulses in the cycle the period logic takes the pending values.
module fpd_regs #(
    parameter int DIV_W      = 12,
    parameter int EDGE_W     = 9,
    parameter int DATA_W     = 32,
    parameter int FALL_LSB   = 16,
    parameter logic [DIV_W-1:0]  RESET_DIV  = 12'h010,
    parameter logic [EDGE_W-1:0] RESET_FALL = 9'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load_done,
    output logic [DIV_W-1:0]  div_pend,
    output logic [EDGE_W-1:0] rise_pend,
    output logic [EDGE_W-1:0] fall_pend,
    output logic              inv,
    output logic              byp,
    output logic              upd
);
    import fpd_pkg::*;

    logic unused_wr_bits;
    assign unused_wr_bits = ^wr_data;

    // Decode writes into pending and control registers; track unapplied updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_pend  <= RESET_DIV;
            rise_pend <= '0;
            fall_pend <= RESET_FALL;
            inv       <= 1'b0;
            byp       <= 1'b0;
            upd       <= 1'b0;
        end else begin
            if (load_done) begin
                upd <= 1'b0;
            end
            if (wr_en) begin
                case (reg_sel_e'(wr_addr))
                    SEL_DIV: begin
                        div_pend <= wr_data[DIV_W-1:0];
                        upd      <= 1'b1;
                    end
                    SEL_EDGE: begin
                        rise_pend <= wr_data[EDGE_W-1:0];
                        fall_pend <= wr_data[FALL_LSB +: EDGE_W];
                        upd       <= 1'b1;
                    end
                    SEL_CTRL: begin
                        inv <= wr_data[CTRL_INV_BIT];
                        byp <= wr_data[CTRL_BYP_BIT];
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/fpd_period.sv
// Period sequencer: counts input cycles within an output period, chooses
// each period's length from the integer part plus the fractional carry,
// and applies pending settings only at a period boundary.
// Assumes the divisor is {integer, fraction} with FRAC_W fraction bits.
module fpd_period #(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 4,
    parameter int EDGE_W = 9,
    parameter logic [INT_W+FRAC_W-1:0] RESET_DIV  = 12'h010,
    parameter logic [EDGE_W-1:0]       RESET_FALL = 9'd1,
    localparam int DIV_W  = INT_W + FRAC_W,
    localparam int PLEN_W = INT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_pend,
    input  logic [EDGE_W-1:0] rise_pend,
    input  logic [EDGE_W-1:0] fall_pend,
    input  logic              upd,
    output logic              load_done,
    output logic              last,
    output logic [PLEN_W-1:0] cnt,
    output logic [PLEN_W-1:0] plen,
    output logic [DIV_W-1:0]  div_act,
    output logic [EDGE_W-1:0] rise_act,
    output logic [EDGE_W-1:0] fall_act
);
    logic [FRAC_W-1:0] acc;
    logic [FRAC_W-1:0] acc_base;
    logic [DIV_W-1:0]  div_src;
    logic [INT_W-1:0]  int_src;
    logic [INT_W-1:0]  int_eff;
    logic [FRAC_W:0]   frac_sum;
    logic [PLEN_W-1:0] next_len;

    // Detect the final cycle of the running period.
    always_comb begin
        last      = (cnt == plen - PLEN_W'(1));
        load_done = last && upd;
    end

    // Length of the next period: clamped integer part plus the fractional carry.
    always_comb begin
        div_src  = upd ? div_pend : div_act;
        acc_base = upd ? '0 : acc;
        int_src  = div_src[DIV_W-1:FRAC_W];
        int_eff  = (int_src == '0) ? INT_W'(1) : int_src;
        frac_sum = {1'b0, acc_base} + {1'b0, div_src[FRAC_W-1:0]};
        next_len = PLEN_W'(int_eff) + PLEN_W'(frac_sum[FRAC_W]);
    end

    // Advance the cycle counter and roll into the next period at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            plen     <= PLEN_W'(1);
            acc      <= '0;
            div_act  <= RESET_DIV;
            rise_act <= '0;
            fall_act <= RESET_FALL;
        end else if (last) begin
            cnt  <= '0;
            plen <= next_len;
            acc  <= frac_sum[FRAC_W-1:0];
            if (upd) begin
                div_act  <= div_pend;
                rise_act <= rise_pend;
                fall_act <= fall_pend;
            end
        end else begin
            cnt <= cnt + PLEN_W'(1);
        end
    end
endmodule

// File: rtl/fpd_wave.sv
// Output shaper: strobe at the first cycle of a period, active level
// between the rising and falling half-cycle positions, then the bypass
// override and the polarity inversion.
// Assumes cnt restarts at zero on every period.
module fpd_wave #(
    parameter int PLEN_W = 9,
    parameter int EDGE_W = 9,
    localparam int CMP_W = ((PLEN_W + 1) > EDGE_W) ? (PLEN_W + 1) : EDGE_W
) (
    input  logic [PLEN_W-1:0] cnt,
    input  logic [EDGE_W-1:0] rise_act,
    input  logic [EDGE_W-1:0] fall_act,
    input  logic              inv,
    input  logic              byp,
    output logic              pix_stb,
    output logic              pix_clk
);
    logic [CMP_W-1:0] half_pos;
    logic             level;

    // Compare the half-cycle position of this cycle with the edge window.
    always_comb begin
        half_pos = CMP_W'({cnt, 1'b0});
        level    = (half_pos >= CMP_W'(rise_act)) && (half_pos < CMP_W'(fall_act));
        pix_stb  = byp || (cnt == '0);
        pix_clk  = (byp || level) ^ inv;
    end
endmodule

// File: rtl/fpclk_div.sv
// Fractional pixel clock divider top: register file, period sequencer
// and output shaper. All logic runs on the fast input clock; the pixel
// clock is delivered as a strobe plus a shaped level.
module fpclk_div #(
    parameter int INT_W    = 8,
    parameter int FRAC_W   = 4,
    parameter int EDGE_W   = 9,
    parameter int DATA_W   = 32,
    parameter int FALL_LSB = 16,
    localparam int DIV_W   = INT_W + FRAC_W,
    localparam int PLEN_W  = INT_W + 1,
    localparam logic [DIV_W-1:0]  RESET_DIV  = DIV_W'(1) << FRAC_W,
    localparam logic [EDGE_W-1:0] RESET_FALL = EDGE_W'(1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pix_stb,
    output logic              pix_clk
);
    logic [DIV_W-1:0]  div_pend;
    logic [EDGE_W-1:0] rise_pend;
    logic [EDGE_W-1:0] fall_pend;
    logic              inv;
    logic              byp;
    logic              upd;
    logic              load_done;
    logic              last;
    logic [PLEN_W-1:0] cnt;
    logic [PLEN_W-1:0] plen;
    logic [DIV_W-1:0]  div_act;
    logic [EDGE_W-1:0] rise_act;
    logic [EDGE_W-1:0] fall_act;

    fpd_regs #(
        .DIV_W(DIV_W), .EDGE_W(EDGE_W), .DATA_W(DATA_W), .FALL_LSB(FALL_LSB),
        .RESET_DIV(RESET_DIV), .RESET_FALL(RESET_FALL)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .load_done(load_done), .div_pend(div_pend),
        .rise_pend(rise_pend), .fall_pend(fall_pend), .inv(inv),
        .byp(byp), .upd(upd)
    );

    fpd_period #(
        .INT_W(INT_W), .FRAC_W(FRAC_W), .EDGE_W(EDGE_W),
        .RESET_DIV(RESET_DIV), .RESET_FALL(RESET_FALL)
    ) u_period (
        .clk(clk), .rst_n(rst_n), .div_pend(div_pend), .rise_pend(rise_pend),
        .fall_pend(fall_pend), .upd(upd), .load_done(load_done), .last(last),
        .cnt(cnt), .plen(plen), .div_act(div_act), .rise_act(rise_act),
        .fall_act(fall_act)
    );

    fpd_wave #(
        .PLEN_W(PLEN_W), .EDGE_W(EDGE_W)
    ) u_wave (
        .cnt(cnt), .rise_act(rise_act), .fall_act(fall_act), .inv(inv),
        .byp(byp), .pix_stb(pix_stb), .pix_clk(pix_clk)
    );
endmodule

// File: rtl/fpd_chk.sv
// Checker for the fractional pixel clock divider, bound into the top.
// Watches the outputs together with the period sequencer's state.
module fpd_chk #(
    parameter int PLEN_W = 9,
    parameter int DIV_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pix_stb,
    input logic              pix_clk,
    input logic              last,
    input logic              byp,
    input logic              inv,
    input logic [PLEN_W-1:0] plen,
    input logic [DIV_W-1:0]  div_act
);
    logic [PLEN_W:0] gap;

    // Count cycles since the most recent strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || pix_stb) gap <= '0;
        else                   gap <= gap + (PLEN_W+1)'(1);
    end

    p_reset_out_r1: assert property (@(posedge clk)
        !rst_n |=> (pix_stb && pix_clk));

    p_gap_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        gap < (PLEN_W+1)'(1 << (PLEN_W - 1)));

    p_len_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        plen != '0);

    p_stb_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> pix_stb);

    p_hold_mid_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !last |=> $stable(div_act));

    p_bypass_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
        byp |-> (pix_stb && (pix_clk == !inv)));
endmodule

bind fpclk_div fpd_chk #(.PLEN_W(PLEN_W), .DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pix_stb(pix_stb), .pix_clk(pix_clk),
    .last(last), .byp(byp), .inv(inv), .plen(plen), .div_act(div_act)
);

// File: tb/sim_fpclk_div.sv
module sim_fpclk_div;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic        pix_stb;
    logic        pix_clk;
    int          errs = 0;
    int          checks = 0;
    bit          done = 1'b0;

    fpclk_div u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pix_stb(pix_stb), .pix_clk(pix_clk)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_stb();
        int n = 0;
        while (!pix_stb && n < 2000) begin
            @(negedge clk);
            n++;
        end
        if (!pix_stb) chk(1'b0, "R4 strobe timeout", 0, 1);
    endtask

    task automatic skip(input int n);
        repeat (n) begin
            @(negedge clk);
            wait_stb();
        end
    endtask

    // Called at a negedge where pix_stb is 1; ends at the next strobe.
    task automatic measure(output int len, output int highs);
        len = 0; highs = 0;
        do begin
            highs += int'(pix_clk);
            len++;
            @(negedge clk);
        end while (!pix_stb && len < 2000);
    endtask

    function automatic int exp_high(input int len, input int r, input int f);
        int n = 0;
        for (int c = 0; c < len; c++) if (r <= 2*c && 2*c < f) n++;
        return n;
    endfunction

    task automatic setup(input int dv, input int r, input int f);
        wr(2'd0, 32'(dv));
        wr(2'd1, 32'((f << 16) | r));
        skip(3);
    endtask

    task automatic run_cfg(input int ip, input int fr, input int r, input int f);
        int len, h, sum, lo;
        lo = (ip == 0) ? 1 : ip;
        setup((ip << 4) | fr, r, f);
        sum = 0;
        for (int k = 0; k < 16; k++) begin
            measure(len, h);
            sum += len;
            chk(len == lo || (fr != 0 && len == lo + 1), "R2 period length", len, lo);
            chk(h == exp_high(len, r, f), "R5 active cycles", h, exp_high(len, r, f));
        end
        chk(sum == 16*lo + fr, (ip == 0) ? "R3 clamped sum" : "R2 sixteen-period sum", sum, 16*lo + fr);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int len, h;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(pix_stb == 1'b1, "R1 reset strobe", int'(pix_stb), 1);
        chk(pix_clk == 1'b1, "R1 reset clock", int'(pix_clk), 1);
        // R4: divide by one strobes every cycle
        for (int k = 0; k < 4; k++) begin
            measure(len, h);
            chk(len == 1, "R4 divide-by-one period", len, 1);
            chk(h == 1, "R1 reset level", h, 1);
        end

        // R2/R5: sweep integer parts and every fraction with a half-period window
        for (int ip = 1; ip <= 6; ip++)
            for (int fr = 0; fr < 16; fr++)
                run_cfg(ip, fr, 0, ip);

        // R3: integer part of zero
        run_cfg(0, 0, 0, 1);
        run_cfg(0, 8, 0, 1);

        // R5: edge window corners
        run_cfg(5, 0, 2, 6);
        run_cfg(5, 0, 6, 2);
        run_cfg(5, 0, 0, 300);
        run_cfg(5, 0, 0, 5);
        run_cfg(3, 5, 1, 3);

        // R6: mid-period divisor write must not shorten the running period
        setup(8 << 4, 0, 8);
        wr(2'd0, 32'h30);
        len = 1;
        while (!pix_stb && len < 2000) begin
            len++;
            @(negedge clk);
        end
        chk(len == 8, "R6 old period kept", len, 8);
        measure(len, h);
        chk(len == 3, "R6 new period applied", len, 3);

        // R7: inversion
        setup(4 << 4, 0, 2);
        wr(2'd2, 32'h1);
        wait_stb();
        for (int k = 0; k < 3; k++) begin
            measure(len, h);
            chk(h == len - exp_high(len, 0, 2), "R7 inverted ones", h, len - exp_high(len, 0, 2));
        end
        wr(2'd2, 32'h0);

        // R8: bypass, plain and inverted
        wr(2'd2, 32'h2);
        for (int k = 0; k < 6; k++) begin
            chk(pix_stb == 1'b1, "R8 bypass strobe", int'(pix_stb), 1);
            chk(pix_clk == 1'b1, "R8 bypass level", int'(pix_clk), 1);
            @(negedge clk);
        end
        wr(2'd2, 32'h3);
        for (int k = 0; k < 4; k++) begin
            chk(pix_clk == 1'b0, "R8 bypass inverted level", int'(pix_clk), 0);
            @(negedge clk);
        end
        wr(2'd2, 32'h0);

        // R9: writes to the unused index change nothing
        setup(4 << 4, 0, 4);
        wr(2'd3, 32'h0001_0030);
        repeat (30) @(negedge clk);
        wait_stb();
        for (int k = 0; k < 4; k++) begin
            measure(len, h);
            chk(len == 4, "R9 period unchanged", len, 4);
            chk(h == 2, "R9 level unchanged", h, 2);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule